// File: doc/BRIEF.md
# DMA channel status and interrupt logic

This block keeps one 32-bit control and status word for every channel of a DMA controller. Software reaches each word over a plain single-cycle register bus. The transfer engine and the request logic report per-channel events as one-cycle pulses: start, end, end-of-receive, request-after-stop, stopped and bus error. Each pulse latches a sticky cause bit. Software clears the sticky bits by writing ones. The control bits in the same word are written directly and go back to the engine as run and mode signals.

The causes are folded into a summary vector with one bit per channel. A channel's summary bit goes high when it has a start or end cause, or when it has a stop, end-of-receive or request-after-stop cause whose own enable bit is set. A bus error alone raises nothing. The summary vector is readable on the bus. Its OR drives one registered controller interrupt line.

Word address `k` for `k < NCH` selects the status word of channel `k`. Word address `NCH` reads the summary vector, zero-extended to 32 bits. Any other address reads zero, and a write to it does nothing.

Top module: `dma_chan_status`

## Requirements
- R1: After reset every channel status word reads 0x00000008 (only bit 3, stopped, set), the summary reads 0 and `irq_o` is 0.
- R2: A write to a channel stores data bits 31..26 and bit 23 as written. Bits 22, 24, 25 and 11..21 are never stored and read 0.
- R3: Bits 0 (bus error), 1 (start), 2 (end) and 9 (end-of-receive) are sticky. A written 1 clears the bit and a written 0 leaves it. Bits 3, 4 and 10 are not taken from the written data.
- R4: A status write that leaves bit 29 (stop irq enable) at 1 clears bit 3 (stopped).
- R5: A status write with both bit 31 (run) and bit 22 (mask-run) at 0 sets bit 3. This takes precedence over R4.
- R6: Writing 1 to bit 24 clears bit 10 (compare status) and writing 1 to bit 25 sets it. When both are 1, bit 10 ends set.
- R7: A read of channel k's status shows bit 8 equal to `req_active[k]` in the same cycle.
- R8: In the cycle after a pulse, the matching bit is set: `ev_buserr` sets bit 0, `ev_start` bit 1, `ev_end` bit 2, `ev_stop` bit 3, `ev_ras` bit 4 and `ev_eor` bit 9. A pulse in the same cycle as a write that would clear the bit wins.
- R9: Summary bit k is high when channel k has any of the following: (bit 29 and bit 3), (bit 28 and bit 9), (bit 23 and bit 4), bit 1, or bit 2. It is readable at word address `NCH`.
- R10: `irq_o` equals the OR of the summary vector as it stood one clock earlier.
- R11: `run_o`, `nodesc_o`, `eor_stop_o`, `eor_jump_o` and `cmp_o` mirror bits 31, 30, 26, 27 and 10 of each channel word.
- R12: A write changes only the addressed channel. Writes to address `NCH` or above change nothing, and reads above `NCH` return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| ev_start | input | NCH | Start cause pulses |
| ev_end | input | NCH | End cause pulses |
| ev_eor | input | NCH | End-of-receive cause pulses |
| ev_ras | input | NCH | Request-after-stop cause pulses |
| ev_stop | input | NCH | Stopped cause pulses |
| ev_buserr | input | NCH | Bus error cause pulses |
| req_active | input | NCH | Live peripheral request per channel |
| run_o | output | NCH | Run bit per channel |
| nodesc_o | output | NCH | No-descriptor-fetch bit per channel |
| eor_stop_o | output | NCH | Stop-on-end-of-receive enable per channel |
| eor_jump_o | output | NCH | Jump-on-end-of-receive enable per channel |
| cmp_o | output | NCH | Compare status per channel |
| irq_sum_o | output | NCH | Per-channel interrupt summary |
| irq_o | output | 1 | Controller interrupt line |

## Verification
The hardest case to reach is a cause pulse arriving in the same cycle as a write that clears that cause. This conflict also covers a stop pulse meeting a write whose stop-enable rule would clear the stopped bit. Directed steps raise the pulse and the write strobe on the same edge. A long pseudo-random sweep then lays sparse event pulses over random writes to all addresses, including the summary address and the unused ones. Every step reads back every channel word and the summary, and compares them with a model built from the write rules.

// File: rtl/dma_chan_status.sv
`timescale 1ns/1ps
module dma_chan_status #(
  parameter int NCH = 16,
  parameter int AW  = $clog2(NCH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NCH-1:0]  ev_start,
  input  logic [NCH-1:0]  ev_end,
  input  logic [NCH-1:0]  ev_eor,
  input  logic [NCH-1:0]  ev_ras,
  input  logic [NCH-1:0]  ev_stop,
  input  logic [NCH-1:0]  ev_buserr,
  input  logic [NCH-1:0]  req_active,
  output logic [NCH-1:0]  run_o,
  output logic [NCH-1:0]  nodesc_o,
  output logic [NCH-1:0]  eor_stop_o,
  output logic [NCH-1:0]  eor_jump_o,
  output logic [NCH-1:0]  cmp_o,
  output logic [NCH-1:0]  irq_sum_o,
  output logic            irq_o
);

  localparam logic [31:0] KEEP_M = 32'h0000_061F;
  localparam logic [31:0] W1C_M  = 32'h0000_0207;
  localparam logic [31:0] CTRL_M = 32'hFC80_0000;
  localparam logic [31:0] RST_V  = 32'h0000_0008;

  logic [NCH-1:0][31:0] st_all;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic        sel;
    logic [31:0] st, wv, nx;

    assign sel = bus_we && (bus_addr == AW'(i));

    always_comb begin
      wv = (st & KEEP_M & ~(bus_wdata & W1C_M)) | (bus_wdata & CTRL_M);
      if (wv[29]) wv[3] = 1'b0;
      if (!bus_wdata[31] && !bus_wdata[22]) wv[3] = 1'b1;
      if (bus_wdata[24]) wv[10] = 1'b0;
      if (bus_wdata[25]) wv[10] = 1'b1;
      nx = sel ? wv : st;
      nx[0] = nx[0] | ev_buserr[i];
      nx[1] = nx[1] | ev_start[i];
      nx[2] = nx[2] | ev_end[i];
      nx[3] = nx[3] | ev_stop[i];
      nx[4] = nx[4] | ev_ras[i];
      nx[9] = nx[9] | ev_eor[i];
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) st <= RST_V;
      else        st <= nx;

    assign st_all[i]     = st;
    assign run_o[i]      = st[31];
    assign nodesc_o[i]   = st[30];
    assign eor_jump_o[i] = st[27];
    assign eor_stop_o[i] = st[26];
    assign cmp_o[i]      = st[10];
    assign irq_sum_o[i]  = (st[29] & st[3]) | (st[28] & st[9]) |
                           (st[23] & st[4]) | st[1] | st[2];
  end

  always_comb begin
    bus_rdata = '0;
    for (int j = 0; j < NCH; j++)
      if (bus_addr == AW'(j))
        bus_rdata = st_all[j] | (32'(req_active[j]) << 8);
    if (bus_addr == AW'(NCH))
      bus_rdata = 32'(irq_sum_o);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |irq_sum_o;

endmodule

// File: rtl/dma_chan_status_chk.sv
`timescale 1ns/1ps
module dma_chan_status_chk #(
  parameter int NCH = 16,
  parameter int AW  = $clog2(NCH + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [AW-1:0]        bus_addr,
  input logic                 bus_we,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          bus_rdata,
  input logic [NCH-1:0]       ev_start,
  input logic [NCH-1:0]       ev_stop,
  input logic [NCH-1:0]       req_active,
  input logic [NCH-1:0][31:0] st_all,
  input logic [NCH-1:0]       irq_sum_o,
  input logic                 irq_o
);

  p_irq_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_o == $past(|irq_sum_o));

  for (genvar i = 0; i < NCH; i++) begin : g_c
    p_start_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ev_start[i] |=> st_all[i][1]);

    p_stop_evt_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ev_stop[i] |=> st_all[i][3]);

    p_ctrl_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == AW'(i)) |=>
        (st_all[i][31:26] == $past(bus_wdata[31:26])) &&
        (st_all[i][23] == $past(bus_wdata[23])) && !st_all[i][22]);

    p_halt_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == AW'(i) && !bus_wdata[31] && !bus_wdata[22])
        |=> st_all[i][3]);

    p_cmp_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == AW'(i) && bus_wdata[25]) |=> st_all[i][10]);

    p_pend_view_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == AW'(i)) |-> bus_rdata[8] == req_active[i]);
  end

endmodule

bind dma_chan_status dma_chan_status_chk #(.NCH(NCH), .AW(AW)) u_chk (.*);

// File: tb/test_dma_chan_status.sv
`timescale 1ns/1ps
module test_dma_chan_status;
  localparam int NCH = 4;
  localparam int AW  = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NCH-1:0] ev_start = '0, ev_end = '0, ev_eor = '0, ev_ras = '0;
  logic [NCH-1:0] ev_stop = '0, ev_buserr = '0, req_active = '0;
  logic [NCH-1:0] run_o, nodesc_o, eor_stop_o, eor_jump_o, cmp_o, irq_sum_o;
  logic irq_o;

  dma_chan_status #(.NCH(NCH), .AW(AW)) i_dma_chan_status (.*);

  always #4 clk = ~clk;

  logic [31:0] m [NCH];
  int nvec = 0, nbad = 0;
  logic [31:0] rs = 32'h1234_5678;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mw(input logic [31:0] o, input logic [31:0] w);
    logic [31:0] n;
    n = (o & 32'h0000_061F & ~(w & 32'h0000_0207)) | (w & 32'hFC80_0000);
    if (n[29]) n[3] = 1'b0;
    if (!w[31] && !w[22]) n[3] = 1'b1;
    if (w[24]) n[10] = 1'b0;
    if (w[25]) n[10] = 1'b1;
    return n;
  endfunction

  function automatic logic [NCH-1:0] sumof();
    logic [NCH-1:0] s;
    for (int j = 0; j < NCH; j++)
      s[j] = (m[j][29] & m[j][3]) | (m[j][28] & m[j][9]) |
             (m[j][23] & m[j][4]) | m[j][1] | m[j][2];
    return s;
  endfunction

  task automatic verify(input string tag, input logic old_or);
    logic [5*NCH-1:0] eo, ao;
    for (int j = 0; j < NCH; j++) begin
      bus_addr = AW'(j);
      #0.5;
      chk(tag, bus_rdata, m[j] | (32'(req_active[j]) << 8));
    end
    bus_addr = AW'(NCH);
    #0.5;
    chk("R9", bus_rdata, 32'(sumof()));
    chk("R9", 32'(irq_sum_o), 32'(sumof()));
    chk("R10", 32'(irq_o), 32'(old_or));
    for (int j = 0; j < NCH; j++) begin
      eo[5*j +: 5] = {m[j][31], m[j][30], m[j][26], m[j][27], m[j][10]};
      ao[5*j +: 5] = {run_o[j], nodesc_o[j], eor_stop_o[j], eor_jump_o[j], cmp_o[j]};
    end
    chk("R11", 32'(ao), 32'(eo));
  endtask

  task automatic step(input string tag, input logic [AW-1:0] a, input logic we,
                      input logic [31:0] wd, input logic [NCH-1:0] es, ee, er,
                      ea, ep, eb);
    logic old_or;
    old_or = |sumof();
    bus_addr = a; bus_we = we; bus_wdata = wd;
    ev_start = es; ev_end = ee; ev_eor = er; ev_ras = ea; ev_stop = ep; ev_buserr = eb;
    @(posedge clk);
    for (int j = 0; j < NCH; j++) begin
      if (we && a == AW'(j)) m[j] = mw(m[j], wd);
      m[j][0] = m[j][0] | eb[j];
      m[j][1] = m[j][1] | es[j];
      m[j][2] = m[j][2] | ee[j];
      m[j][3] = m[j][3] | ep[j];
      m[j][4] = m[j][4] | ea[j];
      m[j][9] = m[j][9] | er[j];
    end
    @(negedge clk);
    bus_we = 1'b0;
    ev_start = '0; ev_end = '0; ev_eor = '0; ev_ras = '0; ev_stop = '0; ev_buserr = '0;
    verify(tag, old_or);
  endtask

  task automatic wr(input string tag, input logic [AW-1:0] a, input logic [31:0] wd);
    step(tag, a, 1'b1, wd, '0, '0, '0, '0, '0, '0);
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    return y ^ (y << 5);
  endfunction

  initial begin
    #(8 * 150000);
    nbad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [31:0] r1, r2, r3;
    for (int j = 0; j < NCH; j++) m[j] = 32'h8;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    verify("R1", 1'b0);
    chk("R1", 32'(irq_o), 32'h0);

    wr("R2", 1, 32'hFFFF_FFFF);
    wr("R2", 1, 32'h0480_0000);
    wr("R11", 2, 32'hAC00_0400);

    step("R8", 0, 1'b0, 0, 4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0000, 4'b0001);
    wr("R3", 0, 32'h0000_0000);
    wr("R3", 0, 32'h0000_0002);
    step("R8", 0, 1'b1, 32'h8000_0207, 4'b0001, 4'b0001, 4'b0001, 4'b0, 4'b0, 4'b0001);
    wr("R3", 0, 32'h8000_0207);

    wr("R4", 3, 32'hA000_0000);
    step("R8", 3, 1'b1, 32'hA000_0000, '0, '0, '0, '0, 4'b1000, '0);
    wr("R4", 3, 32'hA000_0000);
    wr("R5", 3, 32'h2000_0000);
    wr("R5", 3, 32'h2040_0000);

    wr("R6", 2, 32'h8200_0000);
    wr("R6", 2, 32'h8100_0000);
    wr("R6", 2, 32'h8300_0000);

    req_active = 4'b0101;
    step("R7", 0, 1'b0, 0, '0, '0, '0, '0, '0, '0);
    req_active = 4'b1010;
    step("R7", 0, 1'b0, 0, '0, '0, '0, '0, '0, '0);
    req_active = '0;

    wr("R9", 1, 32'h8000_0000);
    step("R9", 1, 1'b0, 0, '0, '0, '0, '0, '0, 4'b0010);
    step("R9", 1, 1'b0, 0, '0, '0, 4'b0010, 4'b0010, '0, '0);
    wr("R9", 1, 32'h9000_0000);
    wr("R9", 1, 32'h8080_0200);
    wr("R9", 1, 32'h8000_0000);

    wr("R12", 4, 32'hFFFF_FFFF);
    wr("R12", 5, 32'h0000_0207);
    wr("R12", 7, 32'h0300_0000);
    bus_addr = 3'd6;
    #0.5;
    chk("R12", bus_rdata, 32'h0);

    for (int k = 0; k < 2500; k++) begin
      rs = nxt(rs); r1 = rs;
      rs = nxt(rs); r2 = rs;
      rs = nxt(rs); r3 = rs;
      req_active = r3[NCH-1:0];
      step("R3", r1[2:0], r3[8], r2,
           r3[12 +: NCH] & r2[0 +: NCH] & r1[8 +: NCH],
           r3[16 +: NCH] & r2[4 +: NCH] & r1[12 +: NCH],
           r3[20 +: NCH] & r2[8 +: NCH] & r1[16 +: NCH],
           r3[24 +: NCH] & r2[12 +: NCH] & r1[20 +: NCH],
           r3[28 +: NCH] & r2[16 +: NCH] & r1[24 +: NCH],
           r3[4 +: NCH] & r2[20 +: NCH] & r1[28 +: NCH]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule